// File: doc/BRIEF.md
# Debounced 4x4 Keypad Scanner

This block scans a sixteen-key matrix. It pulls one of four row lines low at a time and watches four column lines for a low level, which means a closed contact in the active row. The row pattern and the settled column pattern together identify a single key. Each full pass over the four rows gives one frame code: the first key found in that pass, or an idle value when nothing was found.

A slower sampling tick feeds frame codes into a ring of recent samples. The visible key code changes only when every sample in the ring agrees. A new non-idle code that follows a stable idle period also raises a one-clock strobe. Both tick rates come from internal dividers of the system clock, so the block can run from one clock domain. The defaults give a scan tick of about 4 kHz and a sampling tick of about 10 Hz from a 33.8688 MHz clock.

Top module: `kpad_scan_top`

## Requirements
- R1: After reset `row_drive` is 1110. On each scan tick it steps through 1110, 1101, 1011, 0111 and then back to 1110. Exactly one row bit is low at any time. Row index r is the position of the low bit, so bit 0 low means row 0.
- R2: The code for a key is 4*r + c. Here c is the position of the single low bit in the synchronized columns, so bit 0 low means column 0. Examples: {row,col} = 1110_1110 gives 0, 1101_1110 gives 4, 0111_0111 gives 15. A valid code always has bit 4 at 0.
- R3: The idle code is 11111. A row whose columns show no low bit, or more than one low bit, yields idle. Idle is never reported with a strobe.
- R4: The columns are checked on the last clock of each row period. A frame ends on the scan tick of row 3. The frame code is the first valid code seen in that frame, so the lowest row wins.
- R5: `col_in` passes through two synchronizing flops before it is decoded. The scan divider must be larger than the number of synchronizer stages.
- R6: On each sampling tick the newest frame code enters an eight-entry ring. `key_code` takes the ring value on the clock after all eight entries agree, and it holds its value otherwise.
- R7: `key_strobe` is high for exactly one clock. It rises on the same edge on which `key_code` takes a new non-idle value, and only if the previous stable value was idle.
- R8: A key held for any length of time gives one strobe. Releasing it until idle is stable re-arms the strobe for the next press.
- R9: A press, or a bouncing contact, that does not give eight matching samples leaves `key_code` and `key_strobe` unchanged.
- R10: Reset is synchronous and active high. It sets the ring, the frame and `key_code` to idle, `key_strobe` to 0, and `row_drive` to 1110.
- R11: Going from one stable key straight to another, with no stable idle between them, updates `key_code` without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| col_in | input | 4 | Column lines; low means a closed contact in the driven row |
| row_drive | output | 4 | Row lines; one bit low at a time |
| key_code | output | 5 | Debounced key code, 11111 when idle |
| key_strobe | output | 1 | One-clock pulse when a new key is accepted |

## Verification
The assertions assume three things. Reset is held from time zero until the first clock edges have passed. The scan divider is larger than the synchronizer depth. The column lines respond only to the row pattern on `row_drive`, never to anything else. The bench builds `col_in` as a combinational function of `row_drive` and a set of pressed keys, and it changes that set only on falling clock edges. Bounce is modelled as a pseudo-random on/off pattern of the pressed set, so the columns always stay consistent with the rows being driven.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
    localparam int ROWS    = 4;
    localparam int COLS    = 4;
    localparam int RIDX_W  = $clog2(ROWS);
    localparam int CIDX_W  = $clog2(COLS);
    localparam int CODE_W  = RIDX_W + CIDX_W + 1;

    typedef logic [ROWS-1:0]   row_t;
    typedef logic [COLS-1:0]   col_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_IDLE = '1;

    // One-cold row and one-cold column give row-major index; anything else is idle.
    function automatic code_t kpad_decode(row_t row, col_t col);
        int zr, zc, ri, ci;
        code_t res;
        zr = 0; zc = 0; ri = 0; ci = 0;
        for (int i = 0; i < ROWS; i++) begin
            if (!row[i]) begin
                zr++;
                ri = i;
            end
        end
        for (int j = 0; j < COLS; j++) begin
            if (!col[j]) begin
                zc++;
                ci = j;
            end
        end
        if (zr == 1 && zc == 1) res = code_t'(ri * COLS + ci);
        else                    res = CODE_IDLE;
        return res;
    endfunction
endpackage

// File: rtl/kpad_tick.sv
module kpad_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/kpad_sync.sv
module kpad_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/kpad_row_scan.sv
module kpad_row_scan
    import kpad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scan_tick,
    input  col_t  col_sync,
    output row_t  row_drive,
    output code_t frame_code
);
    typedef struct packed {
        row_t  row;
        code_t hit;
        code_t frame;
    } scan_st_t;

    localparam scan_st_t SCAN_RST = '{row: ~row_t'(1), hit: CODE_IDLE, frame: CODE_IDLE};

    scan_st_t st_d, st_q;
    code_t    word_code;
    code_t    hit_n;

    always_comb begin
        st_d      = st_q;
        word_code = kpad_decode(st_q.row, col_sync);
        hit_n     = (st_q.hit == CODE_IDLE) ? word_code : st_q.hit;
        if (scan_tick) begin
            st_d.row = {st_q.row[ROWS-2:0], st_q.row[ROWS-1]};
            if (!st_q.row[ROWS-1]) begin
                st_d.frame = hit_n;
                st_d.hit   = CODE_IDLE;
            end else begin
                st_d.hit   = hit_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SCAN_RST;
        else     st_q <= st_d;
    end

    assign row_drive  = st_q.row;
    assign frame_code = st_q.frame;
endmodule

// File: rtl/kpad_debounce.sv
module kpad_debounce
    import kpad_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sample_tick,
    input  code_t frame_code,
    output code_t key_code,
    output logic  key_strobe
);
    typedef struct packed {
        logic [DEPTH-1:0][CODE_W-1:0] ring;
        code_t                        key;
        logic                         armed;
        logic                         strobe;
    } deb_st_t;

    localparam deb_st_t DEB_RST = '{ring: '1, key: CODE_IDLE, armed: 1'b1, strobe: 1'b0};

    deb_st_t          st_d, st_q;
    logic [DEPTH-1:0] eq;
    logic             all_same;

    for (genvar g = 0; g < DEPTH; g++) begin : g_eq
        assign eq[g] = (st_q.ring[g] == st_q.ring[0]);
    end
    assign all_same = &eq;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (all_same) begin
            st_d.key = st_q.ring[0];
            if (st_q.ring[0] == CODE_IDLE) begin
                st_d.armed = 1'b1;
            end else if (st_q.armed) begin
                st_d.strobe = 1'b1;
                st_d.armed  = 1'b0;
            end
        end
        if (sample_tick) st_d.ring = {st_q.ring[DEPTH-2:0], frame_code};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= DEB_RST;
        else     st_q <= st_d;
    end

    assign key_code   = st_q.key;
    assign key_strobe = st_q.strobe;
endmodule

// File: rtl/kpad_scan_top.sv
module kpad_scan_top
    import kpad_pkg::*;
#(
    parameter int SCAN_DIV    = 8467,
    parameter int SAMPLE_DIV  = 3386880,
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COLS-1:0]   col_in,
    output logic [ROWS-1:0]   row_drive,
    output logic [CODE_W-1:0] key_code,
    output logic              key_strobe
);
    logic  scan_tick, sample_tick;
    col_t  col_sync;
    code_t frame_code;

    kpad_tick #(.DIV(SCAN_DIV)) u_scan_tick (
        .clk(clk), .rst(rst), .tick(scan_tick)
    );

    kpad_tick #(.DIV(SAMPLE_DIV)) u_sample_tick (
        .clk(clk), .rst(rst), .tick(sample_tick)
    );

    kpad_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(col_in), .dout(col_sync)
    );

    kpad_row_scan u_rows (
        .clk(clk), .rst(rst), .scan_tick(scan_tick), .col_sync(col_sync),
        .row_drive(row_drive), .frame_code(frame_code)
    );

    kpad_debounce #(.DEPTH(DEPTH)) u_deb (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .frame_code(frame_code),
        .key_code(key_code), .key_strobe(key_strobe)
    );
endmodule

// File: rtl/kpad_scan_chk.sv
module kpad_scan_chk
    import kpad_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ROWS-1:0]   row_drive,
    input logic [CODE_W-1:0] key_code,
    input logic              key_strobe
);
    p_row_onecold_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(~row_drive) == 1);

    p_row_order_r1: assert property (@(posedge clk) disable iff (rst)
        (row_drive != $past(row_drive)) |->
        row_drive == {$past(row_drive[ROWS-2:0]), $past(row_drive[ROWS-1])});

    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (key_code == CODE_IDLE) || (key_code < CODE_W'(ROWS * COLS)));

    p_strobe_nonidle_r3: assert property (@(posedge clk) disable iff (rst)
        key_strobe |-> key_code != CODE_IDLE);

    p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        key_strobe |=> !key_strobe);

    p_strobe_with_change_r7: assert property (@(posedge clk) disable iff (rst)
        key_strobe |-> key_code != $past(key_code));

    p_strobe_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
        key_strobe |-> $past(key_code) == CODE_IDLE);
endmodule

bind kpad_scan_top kpad_scan_chk u_chk (
    .clk(clk), .rst(rst), .row_drive(row_drive), .key_code(key_code), .key_strobe(key_strobe)
);

// File: tb/kpad_scan_top_tb.sv
module kpad_scan_top_tb;
    localparam int SCAN_DIV    = 4;
    localparam int SAMPLE_DIV  = 64;
    localparam int SYNC_STAGES = 2;
    localparam int DEPTH       = 8;
    localparam int IDLE        = 31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  col_in;
    logic [3:0]  row_drive;
    logic [4:0]  key_code;
    logic        key_strobe;
    logic [15:0] press = '0;
    logic [7:0]  lfsr  = 8'hA5;
    int checks = 0, bad = 0, strobes = 0;

    always #2 clk = ~clk;

    kpad_scan_top #(.SCAN_DIV(SCAN_DIV), .SAMPLE_DIV(SAMPLE_DIV),
                    .SYNC_STAGES(SYNC_STAGES), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .col_in(col_in), .row_drive(row_drive),
        .key_code(key_code), .key_strobe(key_strobe)
    );

    // Key matrix: a pressed key grounds its column while its row is driven low.
    always_comb begin
        col_in = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (press[r*4+c] && !row_drive[r]) col_in[c] = 1'b0;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int          m_scan, m_samp, m_row, m_hit, m_frame, m_key;
    logic [3:0]  m_s1, m_s2;
    int          m_ring[$];
    bit          m_armed, m_strobe;

    function automatic int m_word(int r, logic [3:0] c);
        int z = 0, ci = 0;
        for (int i = 0; i < 4; i++) if (!c[i]) begin z++; ci = i; end
        return (z == 1) ? r * 4 + ci : IDLE;
    endfunction

    task automatic m_reset();
        m_scan = 0; m_samp = 0; m_row = 0; m_hit = IDLE; m_frame = IDLE; m_key = IDLE;
        m_s1 = 4'hF; m_s2 = 4'hF; m_armed = 1; m_strobe = 0;
        m_ring.delete();
        repeat (DEPTH) m_ring.push_back(IDLE);
    endtask

    always @(posedge clk) begin
        bit st, sp, same;
        int hn;
        if (rst) m_reset();
        else begin
            st = (m_scan == SCAN_DIV - 1);
            sp = (m_samp == SAMPLE_DIV - 1);
            same = 1;
            foreach (m_ring[i]) if (m_ring[i] != m_ring[0]) same = 0;
            m_strobe = 0;
            if (same) begin
                m_key = m_ring[0];
                if (m_ring[0] == IDLE) m_armed = 1;
                else if (m_armed) begin m_strobe = 1; m_armed = 0; end
            end
            if (sp) begin
                m_ring.push_front(m_frame);
                void'(m_ring.pop_back());
            end
            if (st) begin
                hn = (m_hit == IDLE) ? m_word(m_row, m_s2) : m_hit;
                if (m_row == 3) begin m_frame = hn; m_hit = IDLE; end
                else m_hit = hn;
                m_row = (m_row + 1) % 4;
            end
            m_s2 = m_s1;
            m_s1 = col_in;
            m_scan = st ? 0 : m_scan + 1;
            m_samp = sp ? 0 : m_samp + 1;
        end
    end

    // Per-clock comparison after the edge has settled
    always @(posedge clk) begin
        logic [3:0] exp_row;
        #1;
        exp_row = ~(4'b0001 << m_row);
        chk(row_drive == exp_row, "R1", "row_drive", row_drive, exp_row);
        chk(int'(key_code) == m_key, "R5/R6", "key_code", key_code, m_key);
        chk(key_strobe == m_strobe, "R7", "key_strobe", key_strobe, m_strobe);
        if (key_strobe) strobes++;
    end

    task automatic hold(logic [15:0] m, int n, int bounce);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            press = (i < bounce && lfsr[0]) ? '0 : m;
        end
    endtask

    task automatic release_for(int n);
        @(negedge clk);
        press = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic press_key(int k, int bounce, int exp_code);
        int s0;
        s0 = strobes;
        hold(16'(1) << k, 1200, bounce);
        chk(int'(key_code) == exp_code, "R2", "code of pressed key", key_code, exp_code);
        chk(strobes - s0 == 1, "R7", "strobes per press", strobes - s0, 1);
        release_for(1200);
        chk(int'(key_code) == IDLE, "R3", "code after release", key_code, IDLE);
    endtask

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        chk(row_drive == 4'b1110, "R10", "row in reset", row_drive, 4'b1110);
        chk(int'(key_code) == IDLE, "R10", "code in reset", key_code, IDLE);
        chk(key_strobe == 1'b0, "R10", "strobe in reset", key_strobe, 0);
        rst = 1'b0;

        press_key(0, 300, 0);
        press_key(15, 300, 15);
        press_key(4, 250, 4);
        press_key(1, 0, 1);

        // R8: long hold gives a single strobe, then re-press gives another
        s0 = strobes;
        hold(16'(1) << 10, 2400, 200);
        chk(strobes - s0 == 1, "R8", "strobes over long hold", strobes - s0, 1);
        release_for(1200);
        hold(16'(1) << 10, 1200, 200);
        chk(strobes - s0 == 2, "R8", "strobes after re-press", strobes - s0, 2);
        release_for(1200);

        // R11: direct change without stable idle
        s0 = strobes;
        hold(16'(1) << 6, 1200, 100);
        hold(16'(1) << 9, 1200, 0);
        chk(int'(key_code) == 9, "R11", "code after direct change", key_code, 9);
        chk(strobes - s0 == 1, "R11", "strobes over change", strobes - s0, 1);
        release_for(1200);

        // R3: two keys in one row give idle
        s0 = strobes;
        hold(16'h0300, 1200, 0);
        chk(int'(key_code) == IDLE, "R3", "two keys same row", key_code, IDLE);
        chk(strobes - s0 == 0, "R3", "strobes same row", strobes - s0, 0);
        release_for(600);

        // R4: keys in rows 0 and 3, lowest row wins
        hold((16'(1) << 2) | (16'(1) << 13), 1200, 0);
        chk(int'(key_code) == 2, "R4", "first row wins", key_code, 2);
        release_for(1200);

        // R9: short bouncy press is rejected
        s0 = strobes;
        hold(16'(1) << 7, 300, 300);
        release_for(1200);
        chk(strobes - s0 == 0, "R9", "strobes after glitch", strobes - s0, 0);
        chk(int'(key_code) == IDLE, "R9", "code after glitch", key_code, IDLE);

        // R10: reset while a key is stable
        hold(16'(1) << 5, 1200, 0);
        chk(int'(key_code) == 5, "R2", "code before reset", key_code, 5);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(int'(key_code) == IDLE, "R10", "code after reset", key_code, IDLE);
        chk(row_drive == 4'b1110, "R10", "row after reset", row_drive, 4'b1110);
        press = '0;
        @(negedge clk); rst = 1'b0;
        release_for(200);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        bad++;
        checks++;
        $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule